// File: doc/BRIEF.md
# I2C Slave Bus Front End with High-Speed Entry

This block is the bus side of an I2C slave. It oversamples SCL and SDA on the system clock and finds START, repeated START and STOP conditions. It accepts an address byte and acknowledges it when the 7-bit address matches its own. The R/W bit then selects one of two paths. On a write, the block receives data bytes and passes each one to the host through a one-cycle strobe. On a read, it asks the host for each byte with a one-cycle request and shifts that byte out on SDA.

The own address is `01101` followed by a variant bit (parameter `UPPER_PAIR`) and the strap input `addr_sel`. This gives four addresses, 0110100 to 0110111, so four devices can share one bus.

The block also handles the high-speed master code. This is a first byte of the form 0000_1xxx, sent to every device on the bus. The block refuses the byte with a not-acknowledge and then enters high-speed mode, which the `hs_mode` output reports. High-speed mode stays set across any number of repeated STARTs. Only a STOP returns the block to fast/standard mode. SDA is driven open-drain: `sda_oe` high pulls the line low.

Top module: `i2c_hs_slave_front`

## Requirements
- R1: After reset, `hs_mode`, `sda_oe`, `rx_valid` and `tx_req` are all low, and the block waits for a START.
- R2: The own address is {01101, `UPPER_PAIR`, `addr_sel`}, sent MSB first in bits 7..1 of the first byte after a START. On a match, the slave holds SDA low through the ninth SCL high period (ACK).
- R3: On an address mismatch, the slave does not acknowledge. Until the next START or repeated START it leaves SDA released and gives no `rx_valid` or `tx_req`, even for further clocked bytes.
- R4: With R/W = 0 (bit 0 of the address byte), each following byte is received MSB first. Each byte is acknowledged and reported as a single-cycle `rx_valid` pulse, with the byte on `rx_data`.
- R5: With R/W = 1, `tx_req` pulses once at the ninth SCL rise of the address byte. `tx_data` is captured in that cycle and then driven on SDA MSB first, one bit per SCL low period.
- R6: During a read, a master ACK (SDA low at the ninth SCL rise) produces another `tx_req` and a further byte. A master NACK ends the transfer: SDA stays released and no `tx_req` follows until the next START.
- R7: In fast/standard mode, a first byte matching 0000_1xxx (low three bits ignored) is not acknowledged. SDA stays high through the entire ninth SCL high period. `hs_mode` rises after the ninth SCL falling edge.
- R8: `hs_mode` stays set across repeated STARTs. In high-speed mode, address matching, receive and transmit work as in R2 to R6.
- R9: A STOP (SDA rising while SCL is high) clears `hs_mode` and releases SDA. After the STOP, the next START is handled in fast/standard mode.
- R10: While `hs_mode` is set, a 0000_1xxx byte is treated as a non-matching address. It is not acknowledged and leaves `hs_mode` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| addr_sel | input | 1 | Strap selecting the low or high address of the pair |
| tx_data | input | 8 | Byte to transmit, captured while `tx_req` is high |
| sda_oe | output | 1 | High pulls SDA low |
| rx_valid | output | 1 | Single-cycle strobe marking a received data byte |
| rx_data | output | 8 | Last received data byte |
| tx_req | output | 1 | Single-cycle request for the next transmit byte |
| hs_mode | output | 1 | High while the bus is in high-speed mode |

## Verification
The bench puts two instances on a shared open-drain bus, one for each value of `UPPER_PAIR`. It drives write, read, mismatched-address and master-code sequences through them:
- The four addresses with both strap values separate the variant bit from the strap bit.
- A matched write sent after a mismatched one shows that traffic following a mismatch is ignored, and that a repeated START resumes address matching.
- Reads ended by a master ACK and then a NACK separate continuation from termination. An extra byte clocked after the NACK reads back all ones.
- The master code is sent in both modes, with repeated STARTs and a final STOP in between. This tells apart the refusal that enters high-speed mode, persistence across repeated STARTs, the exit on STOP, and the ignored code once the block is already in high-speed mode.

// File: rtl/i2c_hs_slave_front.sv
module i2c_hs_slave_front #(
  parameter bit UPPER_PAIR = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       addr_sel,
  input  logic [7:0] tx_data,
  output logic       sda_oe,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       tx_req,
  output logic       hs_mode
);

  localparam logic [4:0] ADDR_TOP  = 5'b01101;
  localparam logic [4:0] HS_PREFIX = 5'b00001;
  localparam logic [3:0] LAST_BIT  = 4'd8;
  localparam logic [3:0] ACK_BIT   = 4'd9;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_RX, ST_TX} st_t;

  logic [2:0] scl_s, sda_s;
  logic [3:0] bitcnt;
  logic [7:0] sh, txsh;
  logic       rw, hs_pend;
  st_t        st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_in};
      sda_s <= {sda_s[1:0], sda_in};
    end
  end

  logic scl_h, sda_h, scl_rise, scl_fall, start_det, stop_det;
  assign scl_h     = scl_s[1];
  assign sda_h     = sda_s[1];
  assign scl_rise  = scl_h & ~scl_s[2];
  assign scl_fall  = ~scl_h & scl_s[2];
  assign start_det = scl_h & scl_s[2] & sda_s[2] & ~sda_h;
  assign stop_det  = scl_h & scl_s[2] & ~sda_s[2] & sda_h;

  logic [6:0] own_addr;
  logic [7:0] byte_in;
  logic       tx_drive_slot;
  assign own_addr      = {ADDR_TOP, UPPER_PAIR, addr_sel};
  assign byte_in       = {sh[6:0], sda_h};
  assign tx_drive_slot = (bitcnt == ACK_BIT) || (bitcnt != 4'd0 && bitcnt < LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      txsh     <= '0;
      rw       <= 1'b0;
      hs_pend  <= 1'b0;
      hs_mode  <= 1'b0;
      sda_oe   <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      tx_req   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_req   <= 1'b0;
      if (stop_det) begin
        st      <= ST_IDLE;
        hs_mode <= 1'b0;
        hs_pend <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (start_det) begin
        st      <= ST_ADDR;
        bitcnt  <= '0;
        hs_pend <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (scl_rise) begin
        unique case (st)
          ST_ADDR, ST_RX: begin
            if (bitcnt < LAST_BIT) begin
              sh     <= byte_in;
              bitcnt <= bitcnt + 4'd1;
              if (st == ST_RX && bitcnt == LAST_BIT - 4'd1) begin
                rx_valid <= 1'b1;
                rx_data  <= byte_in;
              end
            end else begin
              bitcnt <= ACK_BIT;
              if (st == ST_ADDR && !hs_pend && rw) begin
                tx_req <= 1'b1;
                txsh   <= tx_data;
              end
            end
          end
          ST_TX: begin
            if (bitcnt < LAST_BIT) begin
              bitcnt <= bitcnt + 4'd1;
            end else begin
              bitcnt <= ACK_BIT;
              if (!sda_h) begin
                tx_req <= 1'b1;
                txsh   <= tx_data;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        unique case (st)
          ST_ADDR: begin
            if (bitcnt == LAST_BIT) begin
              if (sh[7:1] == own_addr) begin
                rw     <= sh[0];
                sda_oe <= 1'b1;
              end else if (!hs_mode && sh[7:3] == HS_PREFIX) begin
                hs_pend <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end else if (bitcnt == ACK_BIT) begin
              bitcnt <= '0;
              if (hs_pend) begin
                hs_pend <= 1'b0;
                hs_mode <= 1'b1;
                sda_oe  <= 1'b0;
                st      <= ST_IDLE;
              end else if (rw) begin
                st     <= ST_TX;
                sda_oe <= ~txsh[7];
                txsh   <= {txsh[6:0], 1'b0};
              end else begin
                st     <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_RX: begin
            if (bitcnt == LAST_BIT) begin
              sda_oe <= 1'b1;
            end else if (bitcnt == ACK_BIT) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
            end
          end
          ST_TX: begin
            if (tx_drive_slot) begin
              sda_oe <= ~txsh[7];
              txsh   <= {txsh[6:0], 1'b0};
              if (bitcnt == ACK_BIT) bitcnt <= '0;
            end else if (bitcnt == LAST_BIT) begin
              sda_oe <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1 and R3: an idle slave never holds the line
  p_idle_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  // R2: the slave only starts pulling SDA while SCL is low
  p_pull_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(!scl_h));

  // R4: receive strobe lasts a single cycle
  p_rx_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5 and R6: a transmit request always follows an acknowledged ninth clock
  p_txreq_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(!sda_h));

  // R7: high-speed mode is entered only from a refused master code
  p_hs_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> $past(hs_pend));

  // R9: STOP returns to fast/standard mode with SDA released
  p_stop_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!hs_mode && !sda_oe));

endmodule

// File: tb/i2c_hs_slave_front_tb.sv
module i2c_hs_slave_front_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, a0 = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic sda_oe, rx_valid, tx_req, hs_mode;
  logic [7:0] rx_data;
  logic hi_oe, hi_rx_valid, hi_tx_req, hi_hs;
  logic [7:0] hi_rx_data;
  logic sda_bus;
  int n_chk = 0, n_fail = 0, rx_cnt = 0, tx_cnt = 0, hi_rx_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe & ~hi_oe;

  i2c_hs_slave_front #(.UPPER_PAIR(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .addr_sel(a0),
    .tx_data(tx_data), .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_req(tx_req), .hs_mode(hs_mode));

  i2c_hs_slave_front #(.UPPER_PAIR(1'b1)) dut_hi_i (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .addr_sel(a0),
    .tx_data(8'h00), .sda_oe(hi_oe), .rx_valid(hi_rx_valid), .rx_data(hi_rx_data),
    .tx_req(hi_tx_req), .hs_mode(hi_hs));

  always @(negedge clk) begin
    if (rx_valid) begin rx_cnt++; rx_last = rx_data; end
    if (tx_req) tx_cnt++;
    if (hi_rx_valid) hi_rx_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic bus_bit(input logic b, output logic s);
    m_sda = b; wq(); m_scl = 1'b1; wq(); s = sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  // returns 1 for ACK held through the high period, 0 for NACK held through it, 2 otherwise
  task automatic wr_byte(input logic [7:0] b, output int resp);
    logic s, s1, s2;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    m_sda = 1'b1; wq(); m_scl = 1'b1;
    @(negedge clk); s1 = sda_bus;
    repeat (2*Q-2) @(negedge clk); s2 = sda_bus;
    @(negedge clk); m_scl = 1'b0; wq();
    resp = (!s1 && !s2) ? 1 : ((s1 && s2) ? 0 : 2);
  endtask

  task automatic rd_byte(input bit ack, input logic [7:0] next_tx, output logic [7:0] v);
    logic s;
    for (int i = 0; i < 8; i++) begin bus_bit(1'b1, s); v = {v[6:0], s}; end
    tx_data = next_tx;
    bus_bit(!ack, s);
  endtask

  task automatic t_reset();
    chk(hs_mode == 0, "R1 hs_mode", hs_mode, 0);
    chk(sda_oe == 0 && hi_oe == 0, "R1 sda_oe", sda_oe, 0);
    chk(rx_valid == 0 && tx_req == 0, "R1 strobes", {rx_valid, tx_req}, 0);
  endtask

  task automatic t_write();
    int r, c0;
    a0 = 1'b0; c0 = rx_cnt;
    bus_start();
    wr_byte(8'h68, r); chk(r == 1, "R2 ack 0110100", r, 1);
    wr_byte(8'hA5, r); chk(r == 1, "R4 ack data", r, 1);
    chk(rx_last == 8'hA5, "R4 byte A5", rx_last, 8'hA5);
    wr_byte(8'h3C, r); chk(r == 1, "R4 ack data", r, 1);
    chk(rx_last == 8'h3C && rx_cnt == c0 + 2, "R4 byte 3C count", rx_cnt - c0, 2);
    chk(hs_mode == 0, "R7 no hs after write", hs_mode, 0);
    bus_stop();
  endtask

  task automatic t_mismatch();
    int r, c0, t0;
    a0 = 1'b1; c0 = rx_cnt; t0 = tx_cnt;
    bus_start();
    wr_byte(8'h68, r); chk(r == 0, "R3 nack 0110100 with A0 high", r, 0);
    wr_byte(8'h11, r); chk(r == 0, "R3 ignored byte", r, 0);
    chk(rx_cnt == c0 && tx_cnt == t0, "R3 no strobes", rx_cnt - c0, 0);
    bus_start();
    wr_byte(8'h6A, r); chk(r == 1, "R2 ack 0110101", r, 1);
    wr_byte(8'h96, r);
    chk(r == 1 && rx_last == 8'h96, "R4 byte after Sr", rx_last, 8'h96);
    bus_stop();
  endtask

  task automatic t_read();
    int r, t0;
    logic [7:0] v;
    a0 = 1'b1; t0 = tx_cnt; tx_data = 8'hC3;
    bus_start();
    wr_byte(8'h6B, r); chk(r == 1, "R5 ack read address", r, 1);
    chk(tx_cnt == t0 + 1, "R5 first tx_req", tx_cnt - t0, 1);
    rd_byte(1'b1, 8'h5A, v); chk(v == 8'hC3, "R5 first byte", v, 8'hC3);
    rd_byte(1'b0, 8'h00, v); chk(v == 8'h5A, "R6 byte after ACK", v, 8'h5A);
    chk(tx_cnt == t0 + 2, "R6 requests", tx_cnt - t0, 2);
    rd_byte(1'b0, 8'h00, v); chk(v == 8'hFF, "R6 released after NACK", v, 8'hFF);
    chk(tx_cnt == t0 + 2, "R6 no request after NACK", tx_cnt - t0, 2);
    bus_stop();
  endtask

  task automatic t_variant();
    int r, c0, h0;
    a0 = 1'b1; c0 = rx_cnt; h0 = hi_rx_cnt;
    bus_start();
    wr_byte(8'h6E, r); chk(r == 1, "R2 ack 0110111 upper pair", r, 1);
    wr_byte(8'h5E, r);
    chk(r == 1 && hi_rx_data == 8'h5E && hi_rx_cnt == h0 + 1, "R2 upper pair byte", hi_rx_data, 8'h5E);
    chk(rx_cnt == c0, "R3 lower pair silent", rx_cnt - c0, 0);
    bus_start();
    wr_byte(8'h6C, r); chk(r == 0, "R2 nack 0110110 with A0 high", r, 0);
    bus_stop();
  endtask

  task automatic t_hs();
    int r, c0;
    logic [7:0] v;
    a0 = 1'b1;
    bus_start();
    wr_byte(8'h0D, r); chk(r == 0, "R7 master code NACK", r, 0);
    chk(hs_mode == 1 && hi_hs == 1, "R7 hs entered", hs_mode, 1);
    bus_start();
    wr_byte(8'h6A, r); chk(r == 1, "R8 ack in hs", r, 1);
    wr_byte(8'h77, r); chk(r == 1 && rx_last == 8'h77, "R8 rx in hs", rx_last, 8'h77);
    chk(hs_mode == 1, "R8 hs kept", hs_mode, 1);
    tx_data = 8'h81;
    bus_start();
    wr_byte(8'h6B, r);
    rd_byte(1'b0, 8'h00, v); chk(v == 8'h81, "R8 tx in hs", v, 8'h81);
    chk(hs_mode == 1, "R8 hs kept after Sr read", hs_mode, 1);
    c0 = rx_cnt;
    bus_start();
    wr_byte(8'h09, r); chk(r == 0, "R10 master code in hs NACK", r, 0);
    chk(hs_mode == 1 && rx_cnt == c0, "R10 hs unchanged", hs_mode, 1);
    bus_start();
    wr_byte(8'h6A, r); chk(r == 1, "R10 address after ignored code", r, 1);
    bus_stop();
    wq();
    chk(hs_mode == 0 && hi_hs == 0, "R9 STOP clears hs", hs_mode, 0);
    chk(sda_oe == 0, "R9 SDA released", sda_oe, 0);
    bus_start();
    wr_byte(8'h6A, r); wr_byte(8'h42, r);
    chk(r == 1 && rx_last == 8'h42 && hs_mode == 0, "R9 fast/standard after STOP", rx_last, 8'h42);
    bus_stop();
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write();
    t_mismatch();
    t_read();
    t_variant();
    t_hs();
    done = 1;
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_up();
    end
  end
endmodule